// File: doc/BRIEF.md
# Primary Device Reset and Diagnostic Sequencer

This block sequences the reset of the first device on a two-device storage bus. Two events start it. A hardware reset arrives on an active-low bus reset input. A software reset arrives as a control bit that the host sets and later clears. While a sequence runs, the block holds its busy status bit high and starts a stubbed local diagnostic engine. After a hardware reset it watches the shared presence line for a timed window, and it keeps what it saw as a flag that survives later software resets. If the second device is present, the block then waits a bounded time for that device's pass handshake. When the sequence finishes, the block drops busy and raises ready in the same cycle. It also loads the error byte and the five signature bytes.

All delays are cycle counts set by parameters, so a bench can shrink them. The value of `t` below is the number of clock cycles since the sequence start. For a hardware reset, `t = 0` is the first cycle after the bus reset input is sampled high. For a software reset, `t = 0` is the first cycle after the control bit is sampled low. The diagnostic engine reports done `DIAG_CYC` cycles after it is started. The system reset `rst_n` is asynchronous in assertion and is assumed to be released synchronously upstream.

Top module: `pri_rst_seq`

## Requirements
- R1: After `rst_n` is released, the outputs are `busy`=1, `ready`=0 and `pres_drive`=1. The error byte and all signature bytes read 00h.
- R2: While `hw_rst_n` is low, `busy` is 1 and `ready` is 0 from the next cycle on. `busy` stays 1 until the sequence completes.
- R3: `pres_drive` is 1 while the bus reset is low and for cycles `t < REL_CYC` after it is released. It is 0 from `t = REL_CYC` onward and 0 for the whole of a software reset sequence.
- R4: After a hardware reset, the presence line is sampled only in cycles `SAMPLE_DLY <= t < SAMPLE_DLY+SAMPLE_LEN`. A pulse outside that window does not mark the second device present. The block never completes before `t = SAMPLE_DLY+SAMPLE_LEN`.
- R5: After a hardware reset with no presence seen, `ready` rises at `t = max(DIAG_CYC, SAMPLE_DLY+SAMPLE_LEN) + 1`, and error bit 7 is 0.
- R6: With the second device present, the pass line is sampled from `t = SAMPLE_DLY`. If it is first seen in cycle `p`, `ready` rises at `max(DIAG_CYC, SAMPLE_DLY+SAMPLE_LEN, p+1) + 1` and error bit 7 is 0.
- R7: With the second device present and no pass seen, the block completes at `t = PASS_TMO + 1` with error bit 7 set to 1.
- R8: Error bits 6..0 hold the diagnostic result code captured when the local diagnostic reports done.
- R9: At completion the signature bytes read: count 01h, sector 01h, cylinder low 00h, cylinder high 00h, device/head 00h.
- R10: Setting `srst` makes `busy` 1 in the next cycle. The block waits for `srst` to return to 0 and does not sample presence again. It applies the R6/R7 pass wait using the flag from the latest hardware reset, with `t` counted from the clear of `srst`. Without a stored peer, it completes at `t = 1`.
- R11: A low `hw_rst_n`, or an `srst` assertion in any state other than holding for `srst`, abandons the running sequence without completing it and restarts from the busy state. A low `hw_rst_n` has priority.
- R12: `ready` is 1 exactly when `busy` is 0. Both change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_rst_n | input | 1 | Bus hardware reset, active low, synchronous to clk |
| srst | input | 1 | Software reset control bit |
| peer_present | input | 1 | Presence line from the second device, active high |
| peer_pass | input | 1 | Diagnostic pass handshake from the second device, active high |
| diag_code | input | CODE_W | Result code reported by the stubbed local diagnostic |
| busy | output | 1 | Busy status bit |
| ready | output | 1 | Ready status bit |
| pres_drive | output | 1 | This device's drive of the shared presence line |
| err_reg | output | CODE_W+1 | Error byte: bit 7 = peer failure, low bits = local code |
| sig_count | output | 8 | Signature count byte |
| sig_sector | output | 8 | Signature sector byte |
| sig_cyl_lo | output | 8 | Signature cylinder low byte |
| sig_cyl_hi | output | 8 | Signature cylinder high byte |
| sig_devhead | output | 8 | Signature device/head byte |

## Verification
The bench places one-cycle presence pulses just before the sampling window, on its last cycle and just after it. A window that is off by one marks the wrong case as present and changes both the completion time and error bit 7. It delays the pass handshake past the window end and withholds it entirely. A design with a wrong timeout or a wrong pass-sampling start then finishes on the wrong cycle or reports the peer incorrectly. Software resets run after hardware resets that did and did not see the peer, so a design that forgets the stored flag, or samples presence again, completes at the wrong time. Hardware and software resets are also fired into running sequences, and any completion the scoreboard did not predict is reported.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [2:0] {
    ST_HWRST  = 3'd0,
    ST_HWRUN  = 3'd1,
    ST_SWHOLD = 3'd2,
    ST_SWRUN  = 3'd3,
    ST_READY  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic [7:0] count;
    logic [7:0] sector;
    logic [7:0] cyl_lo;
    logic [7:0] cyl_hi;
    logic [7:0] devhead;
  } sig_t;

  localparam sig_t SIG_DONE = '{count: 8'h01, sector: 8'h01,
                                cyl_lo: 8'h00, cyl_hi: 8'h00,
                                devhead: 8'h00};

endpackage

// File: rtl/prs_timer.sv
module prs_timer #(
  parameter int CW   = 7,
  parameter int MAXV = 61
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] t
);

  localparam logic [CW-1:0] MAX_T = CW'(MAXV);

  logic [CW-1:0] t_q;
  logic [CW-1:0] t_d;
  logic          t_en;

  always_comb begin
    t_en = 1'b0;
    t_d  = t_q;
    if (clr) begin
      t_en = 1'b1;
      t_d  = '0;
    end else if (t_q != MAX_T) begin
      t_en = 1'b1;
      t_d  = t_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
    end else if (t_en) begin
      t_q <= t_d;
    end
  end

  assign t = t_q;

endmodule

// File: rtl/prs_diag_stub.sv
module prs_diag_stub #(
  parameter int DIAG_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);

  localparam int DW = $clog2(DIAG_CYC + 1);
  localparam logic [DW-1:0] LOAD_V = DW'(DIAG_CYC);
  localparam logic [DW-1:0] ONE_V  = DW'(1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == ONE_V);

  AST_DIAG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done); // R8

endmodule

// File: rtl/prs_result.sv
module prs_result
  import prs_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_cap,
  input  logic [CODE_W-1:0] code_in,
  input  logic              load,
  input  logic              peer_fail,
  output logic [CODE_W:0]   err_o,
  output sig_t              sig_o
);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W:0]   err_q;
  logic [CODE_W:0]   err_d;
  sig_t              sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_cap) begin
      code_q <= code_in;
    end
  end

  always_comb begin
    err_d = {peer_fail, code_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      sig_q <= '0;
    end else if (load) begin
      err_q <= err_d;
      sig_q <= SIG_DONE;
    end
  end

  assign err_o = err_q;
  assign sig_o = sig_q;

endmodule

// File: rtl/pri_rst_seq.sv
module pri_rst_seq
  import prs_pkg::*;
#(
  parameter int REL_CYC    = 4,
  parameter int SAMPLE_DLY = 8,
  parameter int SAMPLE_LEN = 20,
  parameter int PASS_TMO   = 60,
  parameter int DIAG_CYC   = 12,
  parameter int CODE_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              srst,
  input  logic              peer_present,
  input  logic              peer_pass,
  input  logic [CODE_W-1:0] diag_code,
  output logic              busy,
  output logic              ready,
  output logic              pres_drive,
  output logic [CODE_W:0]   err_reg,
  output logic [7:0]        sig_count,
  output logic [7:0]        sig_sector,
  output logic [7:0]        sig_cyl_lo,
  output logic [7:0]        sig_cyl_hi,
  output logic [7:0]        sig_devhead
);

  localparam int WEND = SAMPLE_DLY + SAMPLE_LEN;
  localparam int MAXC = (PASS_TMO > WEND) ? PASS_TMO : WEND;
  localparam int CW   = $clog2(MAXC + 2);

  localparam logic [CW-1:0] REL_T  = CW'(REL_CYC);
  localparam logic [CW-1:0] DLY_T  = CW'(SAMPLE_DLY);
  localparam logic [CW-1:0] WEND_T = CW'(WEND);
  localparam logic [CW-1:0] TMO_T  = CW'(PASS_TMO);

  seq_state_e    state_q;
  seq_state_e    state_d;
  logic [CW-1:0] t_q;
  logic          tmr_clr;
  logic          diag_start;
  logic          diag_done;
  logic          diag_ok_q, diag_ok_d;
  logic          pres_q, pres_d;
  logic          pass_q, pass_d;
  logic          win_open;
  logic          pass_win;
  logic          wait_over;
  logic          hw_fin;
  logic          sw_fin;
  logic          load;
  sig_t          sig_w;

  // ---------------------------------------------------------------
  // Sub-blocks
  // ---------------------------------------------------------------
  prs_timer #(
    .CW   (CW),
    .MAXV (MAXC + 1)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .t     (t_q)
  );

  prs_diag_stub #(
    .DIAG_CYC (DIAG_CYC)
  ) u_diag (
    .clk   (clk),
    .rst_n (rst_n),
    .start (diag_start),
    .done  (diag_done)
  );

  prs_result #(
    .CODE_W (CODE_W)
  ) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_cap  (diag_done),
    .code_in   (diag_code),
    .load      (load),
    .peer_fail (pres_q && !pass_q),
    .err_o     (err_reg),
    .sig_o     (sig_w)
  );

  // ---------------------------------------------------------------
  // Windows and completion conditions
  // ---------------------------------------------------------------
  always_comb begin
    tmr_clr   = (state_q == ST_HWRST) || (state_q == ST_SWHOLD);
    win_open  = (state_q == ST_HWRUN) && (t_q >= DLY_T) && (t_q < WEND_T);
    pass_win  = ((state_q == ST_HWRUN) || (state_q == ST_SWRUN)) &&
                (t_q >= DLY_T);
    wait_over = !pres_q || pass_q || (t_q >= TMO_T);
    hw_fin    = (state_q == ST_HWRUN) && diag_ok_q &&
                (t_q >= WEND_T) && wait_over;
    sw_fin    = (state_q == ST_SWRUN) && diag_ok_q && wait_over;
  end

  // ---------------------------------------------------------------
  // Sequencer next state
  // ---------------------------------------------------------------
  always_comb begin
    state_d    = state_q;
    diag_start = 1'b0;
    if (!hw_rst_n) begin
      state_d = ST_HWRST;
    end else if (srst && (state_q != ST_SWHOLD)) begin
      state_d    = ST_SWHOLD;
      diag_start = 1'b1;
    end else begin
      unique case (state_q)
        ST_HWRST: begin
          state_d    = ST_HWRUN;
          diag_start = 1'b1;
        end
        ST_HWRUN:  if (hw_fin) state_d = ST_READY;
        ST_SWHOLD: if (!srst)  state_d = ST_SWRUN;
        ST_SWRUN:  if (sw_fin) state_d = ST_READY;
        ST_READY:  state_d = ST_READY;
        default:   state_d = ST_HWRST;
      endcase
    end
  end

  assign load = (state_d == ST_READY) && (state_q != ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HWRST;
    end else begin
      state_q <= state_d;
    end
  end

  // ---------------------------------------------------------------
  // Flags: local diag done, peer presence, peer pass
  // ---------------------------------------------------------------
  always_comb begin
    diag_ok_d = diag_ok_q;
    if (diag_start) begin
      diag_ok_d = 1'b0;
    end else if (diag_done) begin
      diag_ok_d = 1'b1;
    end

    pres_d = pres_q;
    if (state_q == ST_HWRST) begin
      pres_d = 1'b0;
    end else if (win_open && peer_present) begin
      pres_d = 1'b1;
    end

    pass_d = pass_q;
    if (tmr_clr) begin
      pass_d = 1'b0;
    end else if (pass_win && peer_pass) begin
      pass_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_ok_q <= 1'b0;
      pres_q    <= 1'b0;
      pass_q    <= 1'b0;
    end else begin
      diag_ok_q <= diag_ok_d;
      pres_q    <= pres_d;
      pass_q    <= pass_d;
    end
  end

  // ---------------------------------------------------------------
  // Outputs
  // ---------------------------------------------------------------
  assign ready       = (state_q == ST_READY);
  assign busy        = !ready;
  assign pres_drive  = (state_q == ST_HWRST) ||
                       ((state_q == ST_HWRUN) && (t_q < REL_T));
  assign sig_count   = sig_w.count;
  assign sig_sector  = sig_w.sector;
  assign sig_cyl_lo  = sig_w.cyl_lo;
  assign sig_cyl_hi  = sig_w.cyl_hi;
  assign sig_devhead = sig_w.devhead;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  AST_HW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |=> busy && !ready); // R2

  AST_SRST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> busy); // R10

  AST_DRV_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !pres_drive); // R3

  AST_NO_EARLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HWRUN) && (t_q < WEND_T) |=> !ready); // R4

  AST_NOPEER_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !pres_q |-> !err_reg[CODE_W]); // R5

  AST_PASS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_HWRUN) || (state_q == ST_SWRUN)) && pres_q && !pass_q &&
    (t_q < TMO_T) |=> !ready); // R7

  AST_SIG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (sig_count == 8'h01) && (sig_sector == 8'h01) &&
    (sig_cyl_lo == 8'h00) && (sig_cyl_hi == 8'h00) &&
    (sig_devhead == 8'h00)); // R9

endmodule

// File: tb/pri_rst_seq_tb.sv
module pri_rst_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REL  = 4;
  localparam int DLY  = 8;
  localparam int LEN  = 20;
  localparam int TMO  = 60;
  localparam int DIAG = 12;
  localparam int WEND = DLY + LEN;
  localparam int NEVER = 1000000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       peer_present = 1'b0;
  logic       peer_pass = 1'b0;
  logic [6:0] diag_code = '0;
  logic       busy, ready, pres_drive;
  logic [7:0] err_reg;
  logic [7:0] sig_count, sig_sector, sig_cyl_lo, sig_cyl_hi, sig_devhead;

  typedef struct {
    int         cyc;
    logic [7:0] err;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   peer_model = 1'b0;
  bit   finished = 1'b0;
  logic rdy_prev = 1'b0;

  pri_rst_seq #(
    .REL_CYC(REL), .SAMPLE_DLY(DLY), .SAMPLE_LEN(LEN),
    .PASS_TMO(TMO), .DIAG_CYC(DIAG), .CODE_W(7)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .srst(srst),
    .peer_present(peer_present), .peer_pass(peer_pass),
    .diag_code(diag_code), .busy(busy), .ready(ready),
    .pres_drive(pres_drive), .err_reg(err_reg),
    .sig_count(sig_count), .sig_sector(sig_sector),
    .sig_cyl_lo(sig_cyl_lo), .sig_cyl_hi(sig_cyl_hi),
    .sig_devhead(sig_devhead)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops an expected completion each time ready rises
  always @(negedge clk) begin
    if (rst_n && ready && !rdy_prev) begin
      if (sbq.size() == 0) begin
        check("R11", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(e.tag, "completion cycle", cyc, e.cyc);
        check(e.tag, "error bit 7", int'(err_reg[7]), int'(e.err[7]));
        check("R8", "error code bits", int'(err_reg[6:0]), int'(e.err[6:0]));
        check("R9", "signature", int'({sig_count, sig_sector} == 16'h0101 &&
              sig_cyl_lo == 8'h00 && sig_cyl_hi == 8'h00 &&
              sig_devhead == 8'h00), 1);
      end
    end
    rdy_prev = ready;
  end

  // Hardware reset driver. Presence high at negedges [pa,pb), pass high
  // from negedge pp (0 = never); negedge n after release lies in cycle t=n-1.
  task automatic hw_seq(int code, int pa, int pb, int pp, string tag);
    int  t0, p, dt;
    bit  pres, b7;
    @(negedge clk);
    hw_rst_n = 1'b0; srst = 1'b0; peer_present = 1'b0; peer_pass = 1'b0;
    diag_code = 7'(code);
    repeat (3) @(negedge clk);
    check("R2", "busy during bus reset", int'(busy), 1);
    check("R3", "presence drive during bus reset", int'(pres_drive), 1);
    hw_rst_n = 1'b1;
    t0 = cyc;
    pres = (imax(pa, DLY + 1) < imin(pb, WEND + 1));
    p    = (pp > 0) ? imax(pp - 1, DLY) : NEVER;
    dt   = pres ? imax(imax(DIAG, WEND), imin(p + 1, TMO)) : imax(DIAG, WEND);
    b7   = pres && (dt < p + 1);
    sbq.push_back('{t0 + dt + 2, {b7, 7'(code)}, tag});
    peer_model = pres;
    for (int n = 1; n <= dt + 4; n++) begin
      @(negedge clk);
      if (n == REL)     check("R3", "presence drive before release", int'(pres_drive), 1);
      if (n == REL + 1) check("R3", "presence drive released", int'(pres_drive), 0);
      peer_present = (n >= pa) && (n < pb);
      peer_pass    = (pp > 0) && (n >= pp);
    end
    peer_present = 1'b0; peer_pass = 1'b0;
    check("R12", "ready after hw sequence", int'(ready), 1);
    check("R12", "busy after hw sequence", int'(busy), 0);
  endtask

  // Software reset driver: srst held 16 negedges, pass from negedge pp
  task automatic sw_seq(int code, int pp, string tag);
    int  t0, p, dt;
    bit  b7;
    @(negedge clk);
    srst = 1'b1;
    diag_code = 7'(code);
    @(negedge clk);
    check("R10", "busy after srst set", int'(busy), 1);
    check("R12", "ready after srst set", int'(ready), 0);
    repeat (15) @(negedge clk);
    check("R10", "still busy while srst held", int'(busy), 1);
    check("R3", "no presence drive in sw reset", int'(pres_drive), 0);
    srst = 1'b0;
    t0 = cyc;
    p  = (pp > 0) ? imax(pp - 1, DLY) : NEVER;
    dt = peer_model ? imin(p + 1, TMO) : 0;
    b7 = peer_model && (dt < p + 1);
    sbq.push_back('{t0 + dt + 2, {b7, 7'(code)}, tag});
    for (int n = 1; n <= dt + 4; n++) begin
      @(negedge clk);
      peer_pass = (pp > 0) && (n >= pp);
    end
    peer_pass = 1'b0;
    check("R12", "ready after sw sequence", int'(ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 1);
    check("R1", "ready after reset", int'(ready), 0);
    check("R1", "presence drive after reset", int'(pres_drive), 1);
    check("R1", "error after reset", int'(err_reg), 0);
    check("R1", "signature after reset", int'({sig_count, sig_sector, sig_cyl_lo,
          sig_cyl_hi, sig_devhead} == 40'h0), 1);

    hw_seq(7'h00, 0, 0, 0, "R5");                 // no peer
    hw_seq(7'h15, 1, 200, 1, "R6");               // peer, early pass
    hw_seq(7'h2A, 1, 200, 41, "R6");              // peer, late pass
    hw_seq(7'h01, 1, 200, 0, "R7");               // peer, pass timeout
    sw_seq(7'h33, 0, "R10");                      // stored peer, no pass
    sw_seq(7'h34, 3, "R10");                      // stored peer, pass
    hw_seq(7'h05, DLY, DLY + 1, 0, "R4");         // pulse before window
    hw_seq(7'h06, WEND, WEND + 1, 0, "R4");       // pulse on last window cycle
    hw_seq(7'h07, WEND + 1, WEND + 2, 0, "R4");   // pulse after window
    sw_seq(7'h08, 0, "R10");                      // no stored peer

    // R11: software reset fired into a running hardware sequence
    @(negedge clk);
    hw_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    hw_rst_n = 1'b1;
    repeat (14) @(negedge clk);
    peer_model = 1'b0;
    sw_seq(7'h11, 0, "R11");

    // R11: hardware reset fired into a running software sequence
    hw_seq(7'h12, 1, 200, 1, "R11");
    @(negedge clk);
    srst = 1'b1;
    repeat (16) @(negedge clk);
    srst = 1'b0;
    repeat (10) @(negedge clk);
    hw_seq(7'h13, 0, 0, 0, "R11");

    repeat (5) @(negedge clk);
    check("R11", "no pending completions", sbq.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule